// File: doc/BRIEF.md
# Unit Lower Triangular Inverse and Diagonal Reciprocal Engine

This block takes the two factors of a symmetric positive definite matrix written as L·D·Lᵀ. L is unit lower triangular and D is diagonal. From them it produces the two pieces a later stage needs to assemble the full inverse as Pᵀ·D⁻¹·P: the reciprocal diagonal D⁻¹ and the inverse P of L. All values are signed fixed point with `FRAC` fractional bits in a `W`-bit word.

Software or a sequencer writes the strictly lower entries of L and the diagonal of D through a memory-style load port. It then pulses `start`. The reciprocals are formed one after another by a bit-serial divider, and each result passes through a small FIFO on its way to the result store. Because L has ones on its diagonal, P needs no division. P is built one column at a time from multiply-subtract steps. The partial sums for the rows still open circulate through a second FIFO, which is refilled with zeros at the start of each column. When `done` is high, every D⁻¹ and P entry can be read back through a registered read port.

Top module: `ldinv_engine`

## Requirements
- R1: After reset, `busy`, `done` and `div_err` are all 0.
- R2: While `busy` is 0, a load with `ld_sel`=0 writes `ld_data` to L at (`ld_row`,`ld_col`), and only entries with row > col are used. A load with `ld_sel`=1 writes D at index `ld_row`. Any load made while `busy` is 1 is ignored and leaves the stored L and D unchanged.
- R3: A `start` pulse while idle sets `busy` on the next clock edge and clears `done` and `div_err`. A `start` while busy has no effect.
- R4: For each nonzero D entry d, the D⁻¹ entry equals sign(d)·min(⌊2^(2·FRAC)/|d|⌋, 2^(W−1)−1).
- R5: A D entry of zero skips its division, stores 0 as its D⁻¹ entry and sets `div_err`. The remaining entries are still computed. `div_err` then stays 1 until the next accepted `start`.
- R6: After a run, every diagonal entry of P equals 2^FRAC (one), and every entry above the diagonal equals 0.
- R7: For i > j, P(i,j) is formed from acc = 0 by applying, for k = j up to i−1 in ascending order, acc ← sat(acc − ⌊L(i,k)·P(k,j)/2^FRAC⌋). The floor rounds toward minus infinity, and sat clamps to the signed W-bit range.
- R8: The read port returns D⁻¹(`rd_row`) when `rd_sel`=0 and P(`rd_row`,`rd_col`) when `rd_sel`=1. `rd_data` reflects the address presented one clock edge earlier.
- R9: `done` rises when both results are complete and stays high until the next accepted `start`. `busy` and `done` are never 1 together.
- R10: For unit lower triangular L with off-diagonal entries below 0.5 in magnitude, the product L·P matches the identity to within 16 LSB in every entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Load strobe |
| ld_sel | input | 1 | 0: L entry, 1: D entry |
| ld_row | input | $clog2(N) | Row index (D index when ld_sel=1) |
| ld_col | input | $clog2(N) | Column index for L |
| ld_data | input | W | Fixed-point value to store |
| start | input | 1 | Begin a run when idle |
| busy | output | 1 | Run in progress |
| done | output | 1 | Results valid |
| div_err | output | 1 | A zero D entry was found in this run |
| rd_sel | input | 1 | 0: D⁻¹ entry, 1: P entry |
| rd_row | input | $clog2(N) | Row (or D⁻¹ index) to read |
| rd_col | input | $clog2(N) | Column of P to read |
| rd_data | output | W | Registered read data |

## Verification
The hardest conditions to reach from the ports are a zero D entry that sits between nonzero ones, and a load that lands in the middle of a run. The first checks that the division sequence skips one slot and keeps the order of the reciprocals. The second checks that storage is frozen while the block works. The stimulus places a zero at an inner D index and checks both the neighbouring reciprocals and the persistent error flag. It also issues L and D writes, plus a second `start`, while `busy` is high, and then reruns the same inputs to confirm that nothing was disturbed. Directed saturating divisors and several random unit triangular matrices then cover the reciprocal clamp, the exact recurrence and the identity tolerance.

// File: rtl/ldinv_pkg.sv
package ldinv_pkg;

    typedef enum logic [2:0] {
        PH_IDLE      = 3'd0,
        PH_DIV_ISSUE = 3'd1,
        PH_DIV_WAIT  = 3'd2,
        PH_COL_INIT  = 3'd3,
        PH_ZERO_FILL = 3'd4,
        PH_SWEEP     = 3'd5,
        PH_FINISH    = 3'd6
    } phase_e;

endpackage

// File: rtl/ldinv_fifo.sv
module ldinv_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wp;
        logic [PW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wp] = din;
            st_d.wp           = bump(st_q.wp);
        end
        if (pop) begin
            st_d.rp = bump(st_q.rp);
        end
        if (push && !pop) begin
            st_d.cnt = st_q.cnt + CW'(1);
        end else if (pop && !push) begin
            st_d.cnt = st_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout  = st_q.mem[st_q.rp];
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CW'(DEPTH));

    // R7: circulation must never lose or invent an entry
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |-> pop);
    p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/ldinv_recip_div.sv
module ldinv_recip_div #(
    parameter int W    = 16,
    parameter int FRAC = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] den,
    output logic         valid,
    output logic [W-1:0] quo
);
    // Dividend is the constant 2^(2*FRAC); quotient needs QW >= W bits.
    localparam int QW   = 2 * FRAC + 1;
    localparam int CNTW = $clog2(QW + 1);
    localparam logic [QW-1:0] QMAX = QW'((2 ** (W - 1)) - 1);
    localparam logic [W-1:0]  SMAX = W'((2 ** (W - 1)) - 1);

    typedef struct packed {
        logic            busy;
        logic            valid;
        logic            neg;
        logic [CNTW-1:0] cnt;
        logic [W-1:0]    mag;
        logic [W:0]      rem;
        logic [QW-1:0]   dvd;
        logic [QW-1:0]   quo;
        logic [W-1:0]    res;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [W:0]    shifted;
    logic [QW-1:0] qn;
    logic [W-1:0]  clamped;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        shifted    = {st_q.rem[W-1:0], st_q.dvd[QW-1]};
        qn         = '0;
        clamped    = '0;
        if (!st_q.busy) begin
            if (go) begin
                st_d.busy = 1'b1;
                st_d.neg  = den[W-1];
                st_d.mag  = den[W-1] ? (~den + W'(1)) : den;
                st_d.rem  = '0;
                st_d.dvd  = {1'b1, {(QW-1){1'b0}}};
                st_d.quo  = '0;
                st_d.cnt  = '0;
            end
        end else begin
            if (shifted >= {1'b0, st_q.mag}) begin
                st_d.rem = shifted - {1'b0, st_q.mag};
                qn       = {st_q.quo[QW-2:0], 1'b1};
            end else begin
                st_d.rem = shifted;
                qn       = {st_q.quo[QW-2:0], 1'b0};
            end
            st_d.quo = qn;
            st_d.dvd = st_q.dvd << 1;
            st_d.cnt = st_q.cnt + CNTW'(1);
            if (st_q.cnt == CNTW'(QW - 1)) begin
                st_d.busy  = 1'b0;
                st_d.valid = 1'b1;
                clamped    = (qn > QMAX) ? SMAX : qn[W-1:0];
                st_d.res   = st_q.neg ? (~clamped + W'(1)) : clamped;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid = st_q.valid;
    assign quo   = st_q.res;

    // R4: clamped magnitude never reaches the most negative code
    p_quo_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (quo != {1'b1, {(W-1){1'b0}}}));
    // R4: a new division is only requested while the divider is idle
    p_go_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !st_q.busy);

endmodule

// File: rtl/ldinv_engine.sv
module ldinv_engine #(
    parameter int N    = 4,
    parameter int W    = 16,
    parameter int FRAC = 12,
    localparam int AW  = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_en,
    input  logic          ld_sel,
    input  logic [AW-1:0] ld_row,
    input  logic [AW-1:0] ld_col,
    input  logic [W-1:0]  ld_data,
    input  logic          start,
    output logic          busy,
    output logic          done,
    output logic          div_err,
    input  logic          rd_sel,
    input  logic [AW-1:0] rd_row,
    input  logic [AW-1:0] rd_col,
    output logic [W-1:0]  rd_data
);
    import ldinv_pkg::*;

    localparam int CW = $clog2(N + 1);
    localparam logic [W-1:0] ONE = W'(1 << FRAC);
    localparam logic signed [2*W:0] SAT_HI = (2*W+1)'((2 ** (W - 1)) - 1);
    localparam logic signed [2*W:0] SAT_LO = -SAT_HI - (2*W+1)'(1);

    typedef struct packed {
        phase_e                  phase;
        logic [CW-1:0]           idx;
        logic [CW-1:0]           dcnt;
        logic [AW-1:0]           col;
        logic [AW-1:0]           kk;
        logic [AW-1:0]           ii;
        logic                    err;
        logic                    done;
        logic [N-1:0][N-1:0][W-1:0] lm;
        logic [N-1:0][W-1:0]     dv;
        logic [N-1:0][N-1:0][W-1:0] pm;
        logic [N-1:0][W-1:0]     di;
        logic [W-1:0]            rd;
    } eng_st_t;

    eng_st_t st_d, st_q;

    logic         div_go, div_valid;
    logic [W-1:0] div_quo;
    logic         rf_push, rf_empty, rf_full;
    logic [W-1:0] rf_din, rf_dout;
    logic         af_push, af_pop, af_empty, af_full;
    logic [W-1:0] af_din, af_dout;
    logic [W-1:0] step_res;

    // acc - floor(l*p / 2^FRAC), clamped to the signed W-bit range
    function automatic logic [W-1:0] mul_sub(input logic [W-1:0] acc,
                                             input logic [W-1:0] l,
                                             input logic [W-1:0] p);
        logic signed [2*W-1:0] prod;
        logic signed [2*W:0]   diff;
        prod = $signed(l) * $signed(p);
        diff = {{(W+1){acc[W-1]}}, acc} - {prod[2*W-1], (prod >>> FRAC)};
        if (diff > SAT_HI) begin
            diff = SAT_HI;
        end else if (diff < SAT_LO) begin
            diff = SAT_LO;
        end
        return diff[W-1:0];
    endfunction

    ldinv_recip_div #(.W(W), .FRAC(FRAC)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (div_go),
        .den   (st_q.dv[st_q.idx[AW-1:0]]),
        .valid (div_valid),
        .quo   (div_quo)
    );

    ldinv_fifo #(.W(W), .DEPTH(N)) u_recip_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rf_push),
        .din   (rf_din),
        .pop   (!rf_empty),
        .dout  (rf_dout),
        .empty (rf_empty),
        .full  (rf_full)
    );

    ldinv_fifo #(.W(W), .DEPTH(N)) u_acc_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (af_push),
        .din   (af_din),
        .pop   (af_pop),
        .dout  (af_dout),
        .empty (af_empty),
        .full  (af_full)
    );

    always_comb begin
        st_d     = st_q;
        div_go   = 1'b0;
        rf_push  = 1'b0;
        rf_din   = '0;
        af_push  = 1'b0;
        af_din   = '0;
        af_pop   = 1'b0;
        step_res = mul_sub(af_dout, st_q.lm[st_q.ii][st_q.kk], st_q.pm[st_q.kk][st_q.col]);

        // reciprocals leave their FIFO in arrival order
        if (!rf_empty) begin
            st_d.di[st_q.dcnt[AW-1:0]] = rf_dout;
            st_d.dcnt                  = st_q.dcnt + CW'(1);
        end

        if (rd_sel) begin
            st_d.rd = st_q.pm[rd_row][rd_col];
        end else begin
            st_d.rd = st_q.di[rd_row];
        end

        case (st_q.phase)
            PH_IDLE: begin
                if (ld_en) begin
                    if (ld_sel) begin
                        st_d.dv[ld_row] = ld_data;
                    end else if (ld_row > ld_col) begin
                        st_d.lm[ld_row][ld_col] = ld_data;
                    end
                end
                if (start) begin
                    st_d.pm    = '0;
                    st_d.err   = 1'b0;
                    st_d.done  = 1'b0;
                    st_d.idx   = '0;
                    st_d.dcnt  = '0;
                    st_d.phase = PH_DIV_ISSUE;
                end
            end
            PH_DIV_ISSUE: begin
                if (st_q.idx == CW'(N)) begin
                    st_d.col   = '0;
                    st_d.phase = PH_COL_INIT;
                end else if (st_q.dv[st_q.idx[AW-1:0]] == '0) begin
                    rf_push  = 1'b1;
                    st_d.err = 1'b1;
                    st_d.idx = st_q.idx + CW'(1);
                end else begin
                    div_go     = 1'b1;
                    st_d.phase = PH_DIV_WAIT;
                end
            end
            PH_DIV_WAIT: begin
                if (div_valid) begin
                    rf_push    = 1'b1;
                    rf_din     = div_quo;
                    st_d.idx   = st_q.idx + CW'(1);
                    st_d.phase = PH_DIV_ISSUE;
                end
            end
            PH_COL_INIT: begin
                st_d.pm[st_q.col][st_q.col] = ONE;
                if (st_q.col == AW'(N - 1)) begin
                    st_d.phase = PH_FINISH;
                end else begin
                    st_d.ii    = st_q.col + AW'(1);
                    st_d.phase = PH_ZERO_FILL;
                end
            end
            PH_ZERO_FILL: begin
                af_push = 1'b1;
                if (st_q.ii == AW'(N - 1)) begin
                    st_d.kk    = st_q.col;
                    st_d.ii    = st_q.col + AW'(1);
                    st_d.phase = PH_SWEEP;
                end else begin
                    st_d.ii = st_q.ii + AW'(1);
                end
            end
            PH_SWEEP: begin
                af_pop = 1'b1;
                if (st_q.ii == st_q.kk + AW'(1)) begin
                    st_d.pm[st_q.ii][st_q.col] = step_res;
                end else begin
                    af_push = 1'b1;
                    af_din  = step_res;
                end
                if (st_q.ii == AW'(N - 1)) begin
                    if (st_q.kk == AW'(N - 2)) begin
                        st_d.col   = st_q.col + AW'(1);
                        st_d.phase = PH_COL_INIT;
                    end else begin
                        st_d.kk = st_q.kk + AW'(1);
                        st_d.ii = st_q.kk + AW'(2);
                    end
                end else begin
                    st_d.ii = st_q.ii + AW'(1);
                end
            end
            PH_FINISH: begin
                if (st_q.dcnt == CW'(N)) begin
                    st_d.done  = 1'b1;
                    st_d.phase = PH_IDLE;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy    = (st_q.phase != PH_IDLE);
    assign done    = st_q.done;
    assign div_err = st_q.err;
    assign rd_data = st_q.rd;

    p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);
    p_load_blocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(st_q.lm) && $stable(st_q.dv)));
    p_err_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (div_err && !(!busy && start)) |=> div_err);
    p_busy_done_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    p_sweep_has_acc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_SWEEP) |-> !af_empty);
    p_recip_room_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_push |-> !rf_full);
    p_acc_room_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (af_push && !af_pop) |-> !af_full);

    for (genvar gr = 0; gr < N; gr++) begin : g_diag_chk
        p_diag_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
            done |-> (st_q.pm[gr][gr] == ONE));
        for (genvar gc = gr + 1; gc < N; gc++) begin : g_upper_chk
            p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
                done |-> (st_q.pm[gr][gc] == '0));
        end
    end

endmodule

// File: tb/ldinv_engine_test.sv
`timescale 1ns/1ps
module ldinv_engine_test;
    localparam int N  = 4;
    localparam int W  = 16;
    localparam int F  = 12;
    localparam int AW = 2;
    localparam longint ONE = 64'sd1 << F;
    localparam longint HI  = (64'sd1 << (W - 1)) - 1;
    localparam longint LO  = -(64'sd1 << (W - 1));

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_en = 1'b0, ld_sel = 1'b0, start = 1'b0;
    logic [AW-1:0] ld_row = '0, ld_col = '0, rd_row = '0, rd_col = '0;
    logic [W-1:0]  ld_data = '0;
    logic          rd_sel = 1'b0;
    logic          busy, done, div_err;
    logic [W-1:0]  rd_data;

    always #4 clk = ~clk;

    ldinv_engine #(.N(N), .W(W), .FRAC(F)) uut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel),
        .ld_row(ld_row), .ld_col(ld_col), .ld_data(ld_data), .start(start),
        .busy(busy), .done(done), .div_err(div_err), .rd_sel(rd_sel),
        .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    longint ml[N][N];
    longint md[N];
    longint mp[N][N];
    longint got_p[N][N];

    typedef struct {
        int     sel;
        int     r;
        int     c;
        longint e;
        string  tag;
    } item_t;
    item_t sbq[$];

    task automatic chk(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
            $finish;
        end
    end

    // monitor: each popped item was addressed at the previous falling edge
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            if (sbq.size() > 0) begin
                it = sbq.pop_front();
                #3;
                if (it.sel == 1) got_p[it.r][it.c] = longint'($signed(rd_data));
                chk(it.tag, longint'($signed(rd_data)), it.e);
            end
        end
    end

    task automatic exp_rd(int sel, int r, int c, longint e, string tag);
        item_t it;
        @(negedge clk);
        rd_sel = sel[0];
        rd_row = r[AW-1:0];
        rd_col = c[AW-1:0];
        it.sel = sel; it.r = r; it.c = c; it.e = e; it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic drain();
        while (sbq.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic load(bit sel, int r, int c, longint v, bit upd);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = sel; ld_row = r[AW-1:0]; ld_col = c[AW-1:0];
        ld_data = v[W-1:0];
        @(negedge clk);
        ld_en = 1'b0;
        if (upd) begin
            if (sel) md[r] = v;
            else     ml[r][c] = v;
        end
    endtask

    function automatic longint sat(longint v);
        if (v > HI) return HI;
        if (v < LO) return LO;
        return v;
    endfunction

    function automatic longint recip(longint d);
        longint m, q;
        if (d == 0) return 0;
        m = (d < 0) ? -d : d;
        q = (64'sd1 << (2 * F)) / m;
        if (q > HI) q = HI;
        return (d < 0) ? -q : q;
    endfunction

    function automatic void build_p();
        for (int j = 0; j < N; j++) begin
            for (int i = 0; i < N; i++) begin
                if (i < j) mp[i][j] = 0;
                else if (i == j) mp[i][j] = ONE;
                else begin
                    longint acc = 0;
                    for (int k = j; k < i; k++)
                        acc = sat(acc - ((ml[i][k] * mp[k][j]) >>> F));
                    mp[i][j] = acc;
                end
            end
        end
    endfunction

    task automatic run();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R3 busy after start", longint'(busy), 1);
        chk("R9 done cleared by start", longint'(done), 0);
        chk("R5 err cleared by start", longint'(div_err), 0);
        while (!done) @(negedge clk);
        chk("R9 busy low with done", longint'(busy), 0);
    endtask

    task automatic check_results(string tag);
        build_p();
        for (int i = 0; i < N; i++)
            exp_rd(0, i, 0, recip(md[i]), (md[i] == 0) ? {"R5 zero slot ", tag} : {"R4 recip ", tag});
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                exp_rd(1, i, j, mp[i][j], (i > j) ? {"R7 P lower ", tag} : {"R6 P diag/upper ", tag});
        drain();
        // R10: L*P close to identity using the values read back
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                longint s = 0, e, dlt;
                for (int k = 0; k <= i; k++)
                    s += ((k == i) ? ONE : ml[i][k]) * got_p[k][j];
                s = s >>> F;
                e = (i == j) ? ONE : 0;
                dlt = (s > e) ? s - e : e - s;
                chk({"R10 L*P identity ", tag}, (dlt <= 16) ? 1 : 0, 1);
            end
        end
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            md[i] = 0;
            for (int j = 0; j < N; j++) begin
                ml[i][j] = 0; got_p[i][j] = 0;
            end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy at reset", longint'(busy), 0);
        chk("R1 done at reset", longint'(done), 0);
        chk("R1 err at reset", longint'(div_err), 0);

        // A: identity L, clamping and sign divisors (R4, R8)
        load(1, 0, 0, 4096, 1);
        load(1, 1, 0, -8192, 1);
        load(1, 2, 0, 1, 1);
        load(1, 3, 0, -32768, 1);
        run();
        chk("R5 no err with nonzero D", longint'(div_err), 0);
        check_results("identity");

        // B: fixed L, zero in an inner D slot
        load(0, 1, 0, 2048, 1);
        load(0, 2, 0, -1024, 1);
        load(0, 2, 1, 1024, 1);
        load(0, 3, 0, 512, 1);
        load(0, 3, 1, -2048, 1);
        load(0, 3, 2, 3072, 1);
        load(1, 0, 0, 12288, 1);
        load(1, 1, 0, -4096, 1);
        load(1, 2, 0, 0, 1);
        load(1, 3, 0, 2000, 1);
        run();
        chk("R5 err raised by zero D", longint'(div_err), 1);
        check_results("zeroD");
        chk("R5 err held after run", longint'(div_err), 1);

        // C: loads and a second start while busy are ignored
        load(1, 2, 0, -3, 1);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        load(0, 3, 0, 7000, 0);
        load(1, 1, 0, 100, 0);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 still busy during blocked loads", longint'(busy), 1);
        while (!done) @(negedge clk);
        chk("R5 err clear with nonzero D", longint'(div_err), 0);
        check_results("busy-load");
        run();
        check_results("busy-load rerun");

        // D: random unit lower triangular trials
        for (int t = 0; t < 5; t++) begin
            for (int i = 1; i < N; i++)
                for (int j = 0; j < i; j++)
                    load(0, i, j, longint'($urandom_range(0, 4095)) - 2048, 1);
            for (int i = 0; i < N; i++) begin
                longint m = longint'($urandom_range(1024, 16383));
                load(1, i, 0, ($urandom_range(0, 1) == 1) ? -m : m, 1);
            end
            run();
            check_results($sformatf("random%0d", t));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule